// File: doc/BRIEF.md
# Posted-Write Bus Master Delivery Engine

This block is the initiator back end of a bus bridge. It takes posted memory-write transactions from the head of a write queue and replays them onto the downstream shared bus. The queue head shows one Dword at a time, together with the byte enables, a marker on the final Dword and the start address of the transaction. The block requests the bus and waits for a grant while the bus is idle. It then runs an address phase followed by data phases, one Dword per clock, and pops each Dword that the target accepts.

Every way a target can end a transaction is handled. After a disconnect, a retry or a preemption by the latency timer, the block later starts a new transaction and resumes at the first Dword that was not delivered. The start address of that transaction is moved forward by four bytes for each Dword already accepted. On a target abort the block pulses a flush to the queue, which discards the rest of that transaction. All bus control pins are active low.

Top module: `posted_write_master`

## Requirements
- R1: While rst_ni is low and the queue is empty, req_no, frame_no and irdy_no are high, and q_pop_o and q_flush_o are low.
- R2: When idle with a valid head entry, req_no is low, even when the bus is busy or not yet granted.
- R3: An address phase starts only on the clock after one in which gnt_ni was low and bus_idle_i was high. In it frame_no is low, irdy_no is high, ad_o carries the start address and cbe_no is 4'b0111 (memory write).
- R4: The first Dword is driven on the clock after the address phase. Each clock in which irdy_no and trdy_ni are both low transfers one Dword and raises q_pop_o.
- R5: In a data clock where the queue has no valid entry, irdy_no is high (master wait state).
- R6: frame_no goes high on the clock that presents the final Dword. After the completing clock, irdy_no is high. A transaction the target fully accepts uses exactly one address phase.
- R7: A target disconnect (stop_ni and devsel_ni low, with or without trdy_ni) ends the transaction. A later transaction resumes at the start address plus 4 times the number of Dwords already transferred.
- R8: A target retry (stop_ni low, trdy_ni high on the first data phase) transfers nothing, and the whole transaction is retried later at the original address.
- R9: A target abort (stop_ni low with devsel_ni high) pulses q_flush_o for one clock. No further Dword of that transaction reaches the bus, and on the next clock frame_no and req_no are high.
- R10: The latency timer expires lat_timer_i clocks after the address phase. Once it has expired while gnt_ni is high, frame_no goes high on the current data phase, and the remaining Dwords go out in later transactions.
- R11: If stop_ni ends a data phase while frame_no is still low, the next clock has frame_no high and irdy_no low, and this holds until stop_ni is released.
- R12: frame_no never returns low on the clock right after it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| q_valid_i | input | 1 | Queue head holds a Dword |
| q_last_i | input | 1 | Head Dword is the final one of its transaction |
| q_addr_i | input | DW | Original start address of the head transaction |
| q_data_i | input | DW | Head Dword |
| q_be_ni | input | DW/8 | Head byte enables, active low |
| q_pop_o | output | 1 | Head Dword accepted by the target |
| q_flush_o | output | 1 | Discard the rest of the head transaction |
| lat_timer_i | input | LT_W | Latency timer setting in clocks |
| gnt_ni | input | 1 | Bus grant, active low |
| bus_idle_i | input | 1 | Bus seen idle |
| trdy_ni | input | 1 | Target ready, active low |
| devsel_ni | input | 1 | Target selected, active low |
| stop_ni | input | 1 | Target stop, active low |
| req_no | output | 1 | Bus request, active low |
| frame_no | output | 1 | Transaction frame, active low |
| irdy_no | output | 1 | Initiator ready, active low |
| ad_o | output | DW | Address or data |
| cbe_no | output | DW/8 | Command or byte enables, active low |

## Verification
Some rules are checked by the assertions on every clock. A transaction starts only after grant and bus idle. The request is withdrawn during transactions. Wait states appear when the queue is empty. The initiator stays ready through a stop handshake. There is a gap after frame rises, and the bus is quiet after an abort. Other properties span several transactions: resume addresses after disconnect, retry and preemption, correct data at each address, the number of address phases, and the discard after an abort. Only the bench scenarios can show these, by comparing a target memory model against the queue contents.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_DATA,
    S_FIN,
    S_TURN
  } pwm_state_e;

  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
endpackage

// File: rtl/pwm_lat_timer.sv
module pwm_lat_timer #(
  parameter int unsigned LT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            run_i,
  input  logic [LT_W-1:0] lt_i,
  output logic            expired_o
);
  logic [LT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (load_i)                        cnt_q <= lt_i;
    else if (run_i && (cnt_q != '0))        cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/pwm_beat_cnt.sv
module pwm_beat_cnt #(
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [DW-1:0] base_i,
  output logic [DW-1:0] addr_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  // resume point: Dwords already accepted move the start address
  assign addr_o = base_i + (DW'(cnt_q) << 2);
endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic q_valid_i,
  input  logic q_last_i,
  input  logic gnt_ni,
  input  logic bus_idle_i,
  input  logic trdy_ni,
  input  logic devsel_ni,
  input  logic stop_ni,
  input  logic lat_exp_i,
  output logic start_o,
  output logic run_o,
  output logic addr_phase_o,
  output logic xfer_o,
  output logic flush_o,
  output logic cnt_clr_o,
  output logic req_no,
  output logic frame_no,
  output logic irdy_no
);
  pwm_state_e state_q, state_d;
  logic final_q, final_d;
  logic in_data, irdy_act, preempt, want_end, frame_act;
  logic phase_done, xfer, abort_hit;

  always_comb begin
    in_data    = (state_q == S_DATA);
    irdy_act   = in_data && q_valid_i;
    preempt    = lat_exp_i && gnt_ni;
    want_end   = irdy_act && (q_last_i || preempt);
    frame_act  = (state_q == S_ADDR) || (in_data && !final_q && !want_end);
    phase_done = irdy_act && (!trdy_ni || !stop_ni);
    xfer       = irdy_act && !trdy_ni;
    abort_hit  = irdy_act && !stop_ni && devsel_ni && trdy_ni;
  end

  always_comb begin
    state_d = state_q;
    final_d = 1'b0;
    unique case (state_q)
      S_IDLE: if (q_valid_i && !gnt_ni && bus_idle_i) state_d = S_ADDR;
      S_ADDR: state_d = S_DATA;
      S_DATA: begin
        final_d = final_q || (want_end && !phase_done);
        if (phase_done) begin
          if (!frame_act)     state_d = S_TURN;
          else if (!stop_ni)  state_d = S_FIN;
        end
      end
      S_FIN:  if (stop_ni) state_d = S_TURN;
      S_TURN: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    if (state_d != S_DATA) final_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      final_q <= 1'b0;
    end else begin
      state_q <= state_d;
      final_q <= final_d;
    end
  end

  assign start_o      = (state_q == S_IDLE) && (state_d == S_ADDR);
  assign run_o        = (state_q == S_ADDR) || in_data;
  assign addr_phase_o = (state_q == S_ADDR);
  assign xfer_o       = xfer;
  assign flush_o      = abort_hit;
  assign cnt_clr_o    = (xfer && q_last_i) || abort_hit;
  assign req_no       = !((state_q == S_IDLE) && q_valid_i);
  assign frame_no     = !frame_act;
  assign irdy_no      = !(irdy_act || (state_q == S_FIN));
endmodule

// File: rtl/posted_write_master.sv
module posted_write_master
  import pwm_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 12,
  parameter int unsigned LT_W  = 8,
  localparam int unsigned BE_W = DW / 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            q_valid_i,
  input  logic            q_last_i,
  input  logic [DW-1:0]   q_addr_i,
  input  logic [DW-1:0]   q_data_i,
  input  logic [BE_W-1:0] q_be_ni,
  output logic            q_pop_o,
  output logic            q_flush_o,
  input  logic [LT_W-1:0] lat_timer_i,
  input  logic            gnt_ni,
  input  logic            bus_idle_i,
  input  logic            trdy_ni,
  input  logic            devsel_ni,
  input  logic            stop_ni,
  output logic            req_no,
  output logic            frame_no,
  output logic            irdy_no,
  output logic [DW-1:0]   ad_o,
  output logic [BE_W-1:0] cbe_no
);
  logic start, run, addr_phase, xfer, cnt_clr, lat_exp;
  logic [DW-1:0] resume_addr;

  pwm_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .q_valid_i   (q_valid_i),
    .q_last_i    (q_last_i),
    .gnt_ni      (gnt_ni),
    .bus_idle_i  (bus_idle_i),
    .trdy_ni     (trdy_ni),
    .devsel_ni   (devsel_ni),
    .stop_ni     (stop_ni),
    .lat_exp_i   (lat_exp),
    .start_o     (start),
    .run_o       (run),
    .addr_phase_o(addr_phase),
    .xfer_o      (xfer),
    .flush_o     (q_flush_o),
    .cnt_clr_o   (cnt_clr),
    .req_no      (req_no),
    .frame_no    (frame_no),
    .irdy_no     (irdy_no)
  );

  pwm_lat_timer #(.LT_W(LT_W)) u_lat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start),
    .run_i    (run),
    .lt_i     (lat_timer_i),
    .expired_o(lat_exp)
  );

  pwm_beat_cnt #(.DW(DW), .CNT_W(CNT_W)) u_beat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .inc_i (xfer),
    .base_i(q_addr_i),
    .addr_o(resume_addr)
  );

  assign q_pop_o = xfer;
  assign ad_o    = addr_phase ? resume_addr : q_data_i;
  assign cbe_no  = addr_phase ? BE_W'(CMD_MEM_WR) : q_be_ni;
endmodule

// File: rtl/posted_write_master_chk.sv
module posted_write_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       q_valid_i,
  input logic       gnt_ni,
  input logic       bus_idle_i,
  input logic       trdy_ni,
  input logic       stop_ni,
  input logic       q_flush_o,
  input logic       req_no,
  input logic       frame_no,
  input logic       irdy_no,
  input logic [3:0] cbe_no
);
  // R3
  addr_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frame_no) |-> ($past(!gnt_ni && bus_idle_i) && irdy_no && (cbe_no == 4'b0111)));

  // R2
  req_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_no |-> (frame_no && irdy_no));

  // R5
  wait_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_no && $past(!frame_no) && !q_valid_i) |-> irdy_no);

  // R6
  irdy_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irdy_no && frame_no && !trdy_ni && stop_ni) |=> irdy_no);

  // R9
  abort_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_flush_o |=> (frame_no && req_no));

  // R11
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(frame_no) && $past(!irdy_no) && $past(!stop_ni)) |-> !irdy_no);

  // R12
  frame_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_no) |=> frame_no);
endmodule

bind posted_write_master posted_write_master_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .q_valid_i (q_valid_i),
  .gnt_ni    (gnt_ni),
  .bus_idle_i(bus_idle_i),
  .trdy_ni   (trdy_ni),
  .stop_ni   (stop_ni),
  .q_flush_o (q_flush_o),
  .req_no    (req_no),
  .frame_no  (frame_no),
  .irdy_no   (irdy_no),
  .cbe_no    (cbe_no)
);

// File: tb/tb_posted_write_master.sv
`timescale 1ns/1ps
module tb_posted_write_master;
  typedef struct packed {
    logic [4:0]  len;
    logic [1:0]  mode;   // 0 normal, 1 disconnect, 2 retry, 3 abort
    logic [3:0]  k;
    logic [7:0]  lat;
    logic        drop;
    logic [3:0]  sidx;
    logic [1:0]  sn;
    logic [31:0] base;
    logic [4:0]  deliv;
    logic [3:0]  txn;
  } row_t;

  localparam int NROWS = 8;
  localparam row_t ROWS [NROWS] = '{
    '{5'd4, 2'd0, 4'd0, 8'd255, 1'b0, 4'd15, 2'd0, 32'h0000_1000, 5'd4, 4'd1},
    '{5'd6, 2'd1, 4'd2, 8'd255, 1'b0, 4'd15, 2'd0, 32'h0000_2000, 5'd6, 4'd3},
    '{5'd5, 2'd2, 4'd0, 8'd255, 1'b0, 4'd15, 2'd0, 32'h0000_3000, 5'd5, 4'd2},
    '{5'd6, 2'd3, 4'd3, 8'd255, 1'b0, 4'd15, 2'd0, 32'h0000_4000, 5'd2, 4'd1},
    '{5'd8, 2'd0, 4'd0, 8'd2,   1'b1, 4'd15, 2'd0, 32'h0000_5000, 5'd8, 4'd4},
    '{5'd5, 2'd0, 4'd0, 8'd255, 1'b0, 4'd2,  2'd2, 32'h0000_6000, 5'd5, 4'd1},
    '{5'd1, 2'd0, 4'd0, 8'd255, 1'b0, 4'd15, 2'd0, 32'h0000_7000, 5'd1, 4'd1},
    '{5'd7, 2'd1, 4'd3, 8'd255, 1'b0, 4'd15, 2'd0, 32'h0000_8000, 5'd7, 4'd3}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic q_valid_i = 1'b0, q_last_i = 1'b0;
  logic [31:0] q_addr_i = '0, q_data_i = '0;
  logic [3:0]  q_be_ni = 4'h0;
  logic [7:0]  lat_timer_i = 8'd255;
  logic gnt_ni = 1'b1, bus_idle_i = 1'b1, trdy_ni = 1'b1, devsel_ni = 1'b1, stop_ni = 1'b1;
  logic q_pop_o, q_flush_o, req_no, frame_no, irdy_no;
  logic [31:0] ad_o;
  logic [3:0]  cbe_no;

  always #4 clk = ~clk;

  posted_write_master dut (
    .clk_i(clk), .rst_ni(rst_ni), .q_valid_i(q_valid_i), .q_last_i(q_last_i),
    .q_addr_i(q_addr_i), .q_data_i(q_data_i), .q_be_ni(q_be_ni),
    .q_pop_o(q_pop_o), .q_flush_o(q_flush_o), .lat_timer_i(lat_timer_i),
    .gnt_ni(gnt_ni), .bus_idle_i(bus_idle_i), .trdy_ni(trdy_ni),
    .devsel_ni(devsel_ni), .stop_ni(stop_ni), .req_no(req_no),
    .frame_no(frame_no), .irdy_no(irdy_no), .ad_o(ad_o), .cbe_no(cbe_no)
  );

  int n_chk = 0, n_bad = 0;
  int head, len, acc, txn, deliv, stall_left, busy_cycles;
  logic [31:0] qdata [16];
  logic [31:0] mem [16];
  bit wr [16];
  logic [31:0] base, cur_addr;
  bit in_data, pend_pop, pend_flush, retry_pend, flush_seen, fin_expect, just_addr, rose_last;
  logic prev_frame;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input row_t r);
    bit stalled, busy, xfer_now;
    int idx;
    @(negedge clk);
    if (pend_flush) head = len;
    else if (pend_pop) head++;
    stalled = in_data && (head == int'(r.sidx)) && (stall_left > 0) && (head < len);
    if (stalled) stall_left--;
    busy = (busy_cycles > 0);
    if (busy) busy_cycles--;
    bus_idle_i  = !busy;
    q_valid_i   = (head < len) && !stalled;
    q_last_i    = (head == len - 1);
    q_data_i    = (head < 16) ? qdata[head] : 32'h0;
    q_addr_i    = base;
    lat_timer_i = r.lat;
    gnt_ni      = r.drop && in_data;
    #1;
    trdy_ni = 1'b1; stop_ni = 1'b1; devsel_ni = 1'b1;
    if (in_data) begin
      devsel_ni = 1'b0; trdy_ni = 1'b0;
      case (r.mode)
        2'd1: if (acc == int'(r.k) - 1) stop_ni = 1'b0;
        2'd2: if (retry_pend) begin trdy_ni = 1'b1; stop_ni = 1'b0; end
        2'd3: if (acc == int'(r.k) - 1) begin devsel_ni = 1'b1; trdy_ni = 1'b1; stop_ni = 1'b0; end
        default: ;
      endcase
    end
    #1;
    if (rose_last) chk(frame_no == 1'b1, "R12", "frame after rise", {31'd0, frame_no}, 32'd1);
    rose_last = (prev_frame == 1'b0) && (frame_no == 1'b1);
    prev_frame = frame_no;
    if (fin_expect) begin
      chk(frame_no == 1'b1 && irdy_no == 1'b0, "R11", "frame/irdy after stop",
          {30'd0, frame_no, irdy_no}, 32'd2);
      fin_expect = 1'b0;
    end
    if (busy && head < len && !in_data) begin
      chk(req_no == 1'b0, "R2", "req while bus busy", {31'd0, req_no}, 32'd0);
      chk(frame_no == 1'b1, "R3", "no start while busy", {31'd0, frame_no}, 32'd1);
    end
    if (in_data && !q_valid_i)
      chk(irdy_no == 1'b1, "R5", "irdy with empty queue", {31'd0, irdy_no}, 32'd1);
    if (just_addr && q_valid_i)
      chk(irdy_no == 1'b0, "R4", "first dword after address", {31'd0, irdy_no}, 32'd0);
    just_addr = 1'b0;
    xfer_now = in_data && !irdy_no && !trdy_ni;
    chk(q_pop_o == xfer_now, "R4", "pop per transfer", {31'd0, q_pop_o}, {31'd0, xfer_now});
    if (!frame_no && irdy_no && !in_data) begin
      chk(cbe_no == 4'b0111, "R3", "command", {28'd0, cbe_no}, 32'h7);
      chk(ad_o == base + 32'(deliv * 4), "R7", "start address", ad_o, base + 32'(deliv * 4));
      cur_addr = ad_o; in_data = 1'b1; just_addr = 1'b1; acc = 0; txn++;
    end else if (in_data && !irdy_no) begin
      if (!trdy_ni) begin
        idx = int'((cur_addr - base) >> 2);
        if (idx >= 0 && idx < 16) begin mem[idx] = ad_o; wr[idx] = 1'b1; end
        else chk(1'b0, "R7", "address range", cur_addr, base);
        if (head == len - 1)
          chk(frame_no == 1'b1, "R6", "frame on final dword", {31'd0, frame_no}, 32'd1);
        cur_addr += 4; acc++; deliv++;
      end
      if (!trdy_ni || !stop_ni) begin
        if (!stop_ni && r.mode == 2'd2) retry_pend = 1'b0;
        if (frame_no) in_data = 1'b0;
        else if (!stop_ni) begin in_data = 1'b0; fin_expect = 1'b1; end
      end
    end
    pend_pop = q_pop_o;
    pend_flush = q_flush_o;
    if (q_flush_o) flush_seen = 1'b1;
  endtask

  function automatic string tag_of(input row_t r);
    if (r.mode == 2'd3) return "R9";
    if (r.mode == 2'd2) return "R8";
    if (r.mode == 2'd1) return "R7";
    if (r.drop)         return "R10";
    if (r.sn != 2'd0)   return "R5";
    return "R6";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", 32'd0, 32'd1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    head = 0; len = 0; in_data = 0; pend_pop = 0; pend_flush = 0; fin_expect = 0;
    just_addr = 0; rose_last = 0; prev_frame = 1'b1; busy_cycles = 0; deliv = 0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(req_no == 1'b1, "R1", "req in reset", {31'd0, req_no}, 32'd1);
    chk(frame_no == 1'b1, "R1", "frame in reset", {31'd0, frame_no}, 32'd1);
    chk(irdy_no == 1'b1, "R1", "irdy in reset", {31'd0, irdy_no}, 32'd1);
    chk(q_pop_o == 1'b0 && q_flush_o == 1'b0, "R1", "pop/flush in reset",
        {30'd0, q_pop_o, q_flush_o}, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int ri = 0; ri < NROWS; ri++) begin
      automatic row_t r = ROWS[ri];
      automatic string tg = tag_of(r);
      automatic int idle_cnt = 0;
      automatic bit done = 1'b0;
      len = int'(r.len); head = 0; base = r.base; acc = 0; txn = 0; deliv = 0;
      stall_left = int'(r.sn); retry_pend = (r.mode == 2'd2); flush_seen = 1'b0;
      busy_cycles = (ri == 0) ? 4 : 0;
      for (int i = 0; i < 16; i++) begin
        qdata[i] = 32'hC0DE_0000 | (32'(ri) << 8) | 32'(i);
        mem[i] = '0; wr[i] = 1'b0;
      end
      for (int cyc = 0; cyc < 400 && !done; cyc++) begin
        step(r);
        if (head >= len && !in_data && frame_no && irdy_no) idle_cnt++;
        else idle_cnt = 0;
        if (idle_cnt >= 3) done = 1'b1;
      end
      chk(done, tg, "row completion", {31'd0, done}, 32'd1);
      for (int i = 0; i < len; i++) begin
        automatic bit exp_wr = (i < int'(r.deliv));
        chk(wr[i] == exp_wr, tg, "dword written", {31'd0, wr[i]}, {31'd0, exp_wr});
        if (exp_wr) chk(mem[i] == qdata[i], tg, "dword data", mem[i], qdata[i]);
      end
      chk(txn == int'(r.txn), tg, "address phases", 32'(txn), 32'(r.txn));
      if (r.mode == 2'd3) begin
        chk(flush_seen, "R9", "flush pulse", {31'd0, flush_seen}, 32'd1);
        chk(req_no == 1'b1, "R9", "no request after abort", {31'd0, req_no}, 32'd1);
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule